// File: doc/BRIEF.md
# Fine-Grain Barrel Thread Scheduler

This block picks one hardware thread in every clock cycle to place its next instruction into a shared in-order pipeline. It holds one program counter per thread and presents the fetch address with the thread number beside it. The pick moves round-robin on every cycle, and threads whose enable is low are passed over. The pick never stays on one thread for two cycles in a row while another thread is enabled. Because of this, dependent instructions of one thread are spaced far enough apart that the pipeline needs no forwarding and no interlocks.

The thread number of each issued slot is carried down a chain of stage registers. Each pipeline stage can read that number to select the per-thread state it reads or writes. The last stage serves as the writeback tag. A redirect input replaces the program counter of any one thread, for example after a taken branch. Decode, execution, caches and register files lie outside the block.

Top module: `barrel_sched`

## Requirements
- R1: After reset, thread t's program counter is START_BASE + t*START_STRIDE, all stage tags are invalid, and the first thread considered for issue is thread 0.
- R2: Each cycle, the issued thread (fetch_tid, with fetch_vld high) is the first thread whose thr_en bit is set, searching upward from the thread after the last one issued and wrapping from NTHR-1 to 0.
- R3: When two or more threads are enabled, the thread issued in a cycle differs from the thread issued in the previous cycle.
- R4: When thr_en is all zero, fetch_vld is 0, a bubble enters the tag pipeline, and neither the program counters nor the search start point change.
- R5: fetch_pc is the issuing thread's program counter. After an issue, that counter grows by ISTEP bytes and the counters of all other threads stay unchanged.
- R6: When redir_vld is high, the program counter of thread redir_tid becomes redir_pc at the next edge. This takes priority over the ISTEP advance when that thread issues in the same cycle.
- R7: Stage k (bit k of stg_vld, bits k*TW +: TW of stg_tid) holds the fetch_vld and fetch_tid of k+1 cycles earlier. wb_vld and wb_tid equal the last stage.
- R8: With all NTHR threads enabled, every thread issues exactly once in every NTHR consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_en | input | NTHR | Per-thread issue enable |
| redir_vld | input | 1 | Program counter overwrite request |
| redir_tid | input | TW | Thread whose counter is overwritten |
| redir_pc | input | PCW | New program counter value |
| fetch_vld | output | 1 | An instruction issues this cycle |
| fetch_tid | output | TW | Issuing thread |
| fetch_pc | output | PCW | Fetch address of the issuing thread |
| stg_vld | output | DEPTH | Valid bit of each pipeline stage |
| stg_tid | output | DEPTH*TW | Thread tag of each stage, stage k at bits k*TW |
| wb_vld | output | 1 | Writeback stage valid |
| wb_tid | output | TW | Writeback stage thread tag |

## Verification
The bench first runs with all four threads enabled. This checks the start addresses, the strict 0-1-2-3 rotation, and the spacing of exactly four cycles between issues of one thread. It then steps through all sixteen enable masks in turn. The sparse masks show whether the search skips and wraps correctly, the single-thread masks are the only case where a thread may repeat, and the empty mask must give bubbles that leave the state untouched. Redirects are applied both to a thread that is issuing in that cycle and to an idle thread, which shows whether the overwrite wins over the advance. Each stage tag is compared with the issue history throughout the run.

// File: rtl/barrel_sched.sv
module barrel_sched #(
  parameter int NTHR = 4,
  parameter int PCW = 32,
  parameter int DEPTH = 5,
  parameter int ISTEP = 4,
  parameter logic [31:0] START_BASE = 32'h0000_1000,
  parameter logic [31:0] START_STRIDE = 32'h0000_0100,
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NTHR-1:0]       thr_en,
  input  logic                  redir_vld,
  input  logic [TW-1:0]         redir_tid,
  input  logic [PCW-1:0]        redir_pc,
  output logic                  fetch_vld,
  output logic [TW-1:0]         fetch_tid,
  output logic [PCW-1:0]        fetch_pc,
  output logic [DEPTH-1:0]      stg_vld,
  output logic [DEPTH*TW-1:0]   stg_tid,
  output logic                  wb_vld,
  output logic [TW-1:0]         wb_tid
);

  localparam logic [TW-1:0] LAST = TW'(NTHR - 1);

  logic [TW-1:0]  ptr_q;
  logic [PCW-1:0] pc_q [NTHR];
  logic [TW-1:0]  tag_q [DEPTH];
  logic [DEPTH-1:0] sv_q;
  logic [TW-1:0]  pick;

  always_comb begin
    int j;
    pick = '0;
    fetch_vld = 1'b0;
    for (int k = 0; k < NTHR; k++) begin
      j = int'(ptr_q) + k;
      if (j >= NTHR) j = j - NTHR;
      if (!fetch_vld && thr_en[j]) begin
        fetch_vld = 1'b1;
        pick = TW'(j);
      end
    end
  end

  assign fetch_tid = pick;
  assign fetch_pc  = pc_q[pick];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (fetch_vld) ptr_q <= (pick == LAST) ? '0 : pick + 1'b1;
  end

  for (genvar t = 0; t < NTHR; t++) begin : g_pc
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pc_q[t] <= PCW'(START_BASE + START_STRIDE * t);
      else if (redir_vld && redir_tid == TW'(t))
        pc_q[t] <= redir_pc;
      else if (fetch_vld && pick == TW'(t))
        pc_q[t] <= pc_q[t] + PCW'(ISTEP);
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_stg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sv_q[s]  <= 1'b0;
        tag_q[s] <= '0;
      end else if (s == 0) begin
        sv_q[s]  <= fetch_vld;
        tag_q[s] <= pick;
      end else begin
        sv_q[s]  <= sv_q[(s > 0) ? s - 1 : 0];
        tag_q[s] <= tag_q[(s > 0) ? s - 1 : 0];
      end
    end
    assign stg_tid[s*TW +: TW] = tag_q[s];

    if (s > 0) begin : g_shift_chk
      // R7
      tag_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> stg_vld[s] == $past(stg_vld[s-1]) &&
                  stg_tid[s*TW +: TW] == $past(stg_tid[(s-1)*TW +: TW]));
    end
  end

  assign stg_vld = sv_q;
  assign wb_vld  = sv_q[DEPTH-1];
  assign wb_tid  = tag_q[DEPTH-1];

  // R2
  pick_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_vld |-> thr_en[fetch_tid]);

  // R3
  no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_vld && stg_vld[0] && $countones(thr_en) >= 2) |-> fetch_tid != stg_tid[TW-1:0]);

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && thr_en == '0) |=> (!stg_vld[0] && ptr_q == $past(ptr_q)));

  // R5
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && fetch_vld && !(redir_vld && redir_tid == fetch_tid))
      |=> pc_q[$past(fetch_tid)] == $past(fetch_pc) + PCW'(ISTEP));

  // R6
  redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && redir_vld) |=> pc_q[$past(redir_tid)] == $past(redir_pc));

endmodule

// File: tb/barrel_sched_tb_top.sv
module barrel_sched_tb_top;
  localparam int NTHR = 4, PCW = 32, DEPTH = 5, ISTEP = 4, TW = 2;
  localparam logic [31:0] SB = 32'h1000, SS = 32'h100;

  logic clk = 0, rst_n = 0;
  logic [NTHR-1:0] thr_en = '0;
  logic redir_vld = 0;
  logic [TW-1:0] redir_tid = '0;
  logic [PCW-1:0] redir_pc = '0;
  logic fetch_vld, wb_vld;
  logic [TW-1:0] fetch_tid, wb_tid;
  logic [PCW-1:0] fetch_pc;
  logic [DEPTH-1:0] stg_vld;
  logic [DEPTH*TW-1:0] stg_tid;

  barrel_sched #(.NTHR(NTHR), .PCW(PCW), .DEPTH(DEPTH), .ISTEP(ISTEP),
                 .START_BASE(SB), .START_STRIDE(SS)) dut_i (
    .clk, .rst_n, .thr_en, .redir_vld, .redir_tid, .redir_pc,
    .fetch_vld, .fetch_tid, .fetch_pc, .stg_vld, .stg_tid, .wb_vld, .wb_tid);

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int ref_ptr = 0;
  logic [PCW-1:0] ref_pc [NTHR];
  logic hv [DEPTH];
  int ht [DEPTH];
  int last_iss [NTHR];
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic [NTHR-1:0] en, input bit rv, input int rt,
                      input logic [PCW-1:0] rp, input bit gap_chk);
    int p; bit f;
    @(negedge clk);
    thr_en = en; redir_vld = rv; redir_tid = TW'(rt); redir_pc = rp;
    #1;
    f = 0; p = 0;
    for (int k = 0; k < NTHR; k++) begin
      int j;
      j = (ref_ptr + k) % NTHR;
      if (!f && en[j]) begin f = 1; p = j; end
    end
    chk(fetch_vld == f, "R2/R4 valid", fetch_vld, f);
    if (f) begin
      chk(int'(fetch_tid) == p, "R2 tid", fetch_tid, p);
      chk(fetch_pc == ref_pc[p], "R5 pc", fetch_pc, ref_pc[p]);
      if ($countones(en) >= 2 && hv[0])
        chk(int'(fetch_tid) != ht[0], "R3 repeat", fetch_tid, ht[0]);
      if (gap_chk && last_iss[p] >= 0)
        chk(cyc - last_iss[p] == NTHR, "R8 spacing", cyc - last_iss[p], NTHR);
    end
    for (int s = 0; s < DEPTH; s++) begin
      chk(stg_vld[s] == hv[s], "R7 stage valid", stg_vld[s], hv[s]);
      if (hv[s]) chk(int'(stg_tid[s*TW +: TW]) == ht[s], "R7 stage tid", stg_tid[s*TW +: TW], ht[s]);
    end
    chk(wb_vld == hv[DEPTH-1] && (!wb_vld || int'(wb_tid) == ht[DEPTH-1]),
        "R7 wb", {wb_vld, wb_tid}, {hv[DEPTH-1], ht[DEPTH-1][TW-1:0]});
    @(posedge clk);
    if (f) begin
      ref_pc[p] = ref_pc[p] + ISTEP;
      ref_ptr = (p + 1) % NTHR;
      last_iss[p] = cyc;
    end
    if (rv) ref_pc[rt] = rp;
    for (int s = DEPTH - 1; s > 0; s--) begin hv[s] = hv[s-1]; ht[s] = ht[s-1]; end
    hv[0] = f; ht[0] = p;
    cyc++;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < NTHR; t++) begin
      ref_pc[t] = SB + SS * t;
      last_iss[t] = -1;
    end
    for (int s = 0; s < DEPTH; s++) begin hv[s] = 0; ht[s] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(stg_vld == '0 && !wb_vld, "R1 stages clear", stg_vld, 0);
    chk(!fetch_vld, "R4 idle in reset", fetch_vld, 0);
    rst_n = 1;
    // R1 start addresses and R8 rotation
    for (int i = 0; i < 4 * NTHR; i++) begin
      if (i < NTHR) begin
        #1;
        chk(int'(fetch_tid) == i % NTHR && fetch_pc == SB + SS * i, "R1 start", fetch_pc, SB + SS * i);
      end
      step('1, 0, 0, '0, 1);
    end
    // sweep every enable mask
    for (int m = 0; m < (1 << NTHR); m++)
      for (int r = 0; r < 6; r++) step(NTHR'(m), 0, 0, '0, 0);
    // R6 redirect the issuing thread (priority over advance)
    step('1, 1, ref_ptr, 32'hABCD_0000, 0);
    // R6 redirect an idle thread
    step(4'b0011, 1, 3, 32'h0000_5550, 0);
    for (int r = 0; r < 8; r++) step('1, 0, 0, '0, 0);
    // R4 bubbles with a redirect still applied
    step('0, 1, 1, 32'h0000_7770, 0);
    for (int r = 0; r < DEPTH + 2; r++) step('0, 0, 0, '0, 0);
    for (int r = 0; r < 8; r++) step(4'b1010, 0, 0, '0, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule